// File: doc/BRIEF.md
# Comparator configuration register block

This block holds the configuration and status words for a pair of comparator channels and presents them on a simple single-cycle register port. Channel 0 sits at byte offset 0x00 and channel 1 at 0x04. Every stored field drives the analog front end directly:

- enable
- speed/power class
- plus and minus input selects
- extended minus-pin select
- hysteresis code
- output inversion
- blanking source
- scaler and bridge enables
- the shared window connection (channel 1 only)

The live comparator output, after inversion, can be read back as a status bit.

Each channel word carries a seal. The seal is a two-state machine:

- **OPEN**: the word accepts writes.
- **SEALED**: the word is read-only, including the seal bit itself.

There are two transitions:

- *seal*: an accepted write to the word with bit 31 set moves OPEN to SEALED. The fields carried by that same write are stored.
- *reset*: the system reset returns the machine to OPEN and clears the word. Nothing else leaves SEALED.

A small combinational stage merges the scaler and bridge enables of both channels. It reports which reference tap each channel's minus input actually receives.

The speed/power field is stored as written and its encoding is passed through unchanged: 00 is fastest, 01 and 10 are medium, and 11 is lowest power.

Top module: `cmpcfg_regs`

## Requirements
- R1: After reset both words read 0x0000_0000, every configuration output is 0, and both tap codes are 0.
- R2: Writable bits are [0], [3:2], [6:4], [8:7], [15], [17:16], [20:18], [22], [23] and [26:25]. Bit [9] is also writable, but in channel 1 only. Every other bit reads 0 and ignores writes.
- R3: Writing bit 31 as 1 to an OPEN word seals it. Once sealed, every later write to that word is ignored, including an attempt to clear bit 31. The other channel stays writable. Only reset reopens the word.
- R4: Bit 30 reads the raw comparator output XOR the polarity bit [15]. `cmp_cond` carries the same value. Writes to bit 30 have no effect.
- R5: A write with bits [8:7] = 2'b11 leaves the stored [8:7] unchanged. The other fields of that write are still stored.
- R6: `scaler_on` is 1 when bit 23 is set in either word. `bridge_on` is 1 when bit 22 is set in either word.
- R7: The tap code per channel (3 bits) is computed as follows:
  - It is 0 when the minus select [6:4] is 4 or more, or when the scaler is off.
  - It is 4 (full reference) when the select is 3, or when the bridge is off.
  - Otherwise it is select+1: 1 for a quarter, 2 for a half, 3 for three quarters.
- R8: `cfg_ext_en` is 1 only when the minus select is 3'b111. `cfg_ext_sel` then carries bits [26:25], and is 0 otherwise.
- R9: Accesses to any offset other than 0x00 and 0x04 read 0 and change no state.
- R10: The configuration outputs mirror the stored fields of each word. Channel c uses slice [c] of each 1-bit output and slice [2c+1:2c] of each 2-bit output (or [3c+2:3c] of each 3-bit output). `cfg_win` mirrors channel 1 bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| cmp_raw | input | 2 | Raw comparator outputs from the analog side |
| cmp_cond | output | 2 | Outputs after polarity |
| cfg_en | output | 2 | Channel enables |
| cfg_pwr | output | 4 | Speed/power codes |
| cfg_inp | output | 4 | Plus input selects |
| cfg_inm | output | 6 | Minus input selects |
| cfg_ext_en | output | 2 | Extended minus pin in use |
| cfg_ext_sel | output | 4 | Extended minus pin choice |
| cfg_hyst | output | 4 | Hysteresis codes |
| cfg_pol | output | 2 | Polarity bits |
| cfg_blank | output | 6 | Blanking source codes |
| cfg_win | output | 1 | Plus inputs tied together |
| scaler_on | output | 1 | Shared scaler enable |
| bridge_on | output | 1 | Shared bridge enable |
| ref_tap | output | 6 | Delivered tap code per channel |

## Verification
The seal and the field update land in the same cycle when one write carries bit 31 together with new field values. The bench issues such a write and then reads the word: every field must show the new data and bit 31 must be 1. Later writes must then leave the value untouched, while the neighbouring word keeps changing.

The reserved plus-select rule also acts within a single write. One write can hold its plus select while storing all its other fields, which the bench judges against a model of the word. The tap-code sweep covers all four enable-bit combinations against every minus select.

// File: rtl/cmpcfg_pkg.sv
package cmpcfg_pkg;
    localparam int WORD_W = 32;
    localparam int NCH    = 2;

    localparam int B_EN    = 0;
    localparam int B_PWR   = 2;
    localparam int B_INM   = 4;
    localparam int B_INP   = 7;
    localparam int B_WIN   = 9;
    localparam int B_POL   = 15;
    localparam int B_HYST  = 16;
    localparam int B_BLANK = 18;
    localparam int B_BRG   = 22;
    localparam int B_SCAL  = 23;
    localparam int B_EXT   = 25;
    localparam int B_STAT  = 30;
    localparam int B_SEAL  = 31;

    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_SEALED = 1'b1
    } seal_state_t;

    typedef enum logic [2:0] {
        TAP_NONE    = 3'd0,
        TAP_QUARTER = 3'd1,
        TAP_HALF    = 3'd2,
        TAP_3Q      = 3'd3,
        TAP_FULL    = 3'd4
    } tap_t;

    // Storable field bits of a word (seal and status bits excluded)
    function automatic logic [WORD_W-1:0] field_mask(input bit has_win);
        logic [WORD_W-1:0] m;
        m = '0;
        m[B_EN]         = 1'b1;
        m[B_PWR +: 2]   = 2'b11;
        m[B_INM +: 3]   = 3'b111;
        m[B_INP +: 2]   = 2'b11;
        m[B_WIN]        = has_win;
        m[B_POL]        = 1'b1;
        m[B_HYST +: 2]  = 2'b11;
        m[B_BLANK +: 3] = 3'b111;
        m[B_BRG]        = 1'b1;
        m[B_SCAL]       = 1'b1;
        m[B_EXT +: 2]   = 2'b11;
        return m;
    endfunction
endpackage

// File: rtl/cmpcfg_chan.sv
module cmpcfg_chan
    import cmpcfg_pkg::*;
#(
    parameter bit HAS_WIN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] fields_q,
    output logic              sealed
);
    localparam logic [WORD_W-1:0] MASK = field_mask(HAS_WIN);

    seal_state_t       state_q, state_nxt;
    logic [WORD_W-1:0] fields_nxt;
    logic              accept;

    assign accept = wr_hit && (state_q == LK_OPEN);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_nxt;
    end

    // Transitions: seal on an accepted write carrying bit 31
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            LK_OPEN:   if (wr_hit && wdata[B_SEAL]) state_nxt = LK_SEALED;
            LK_SEALED: state_nxt = LK_SEALED;
        endcase
    end

    // Field update, honouring the reserved plus-select code
    always_comb begin
        fields_nxt = fields_q;
        if (accept) begin
            fields_nxt = wdata & MASK;
            if (wdata[B_INP +: 2] == 2'b11)
                fields_nxt[B_INP +: 2] = fields_q[B_INP +: 2];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fields_q <= '0;
        else        fields_q <= fields_nxt;
    end

    assign sealed = (state_q == LK_SEALED);
endmodule

// File: rtl/cmpcfg_tapsel.sv
module cmpcfg_tapsel
    import cmpcfg_pkg::*;
#(
    parameter int N = NCH
) (
    input  logic [3*N-1:0] inm_sel,
    input  logic [N-1:0]   scal_bits,
    input  logic [N-1:0]   brg_bits,
    output logic           scaler_on,
    output logic           bridge_on,
    output logic [3*N-1:0] tap_code
);
    assign scaler_on = |scal_bits;
    assign bridge_on = |brg_bits;

    for (genvar g = 0; g < N; g++) begin : g_tap
        logic [2:0] s;
        assign s = inm_sel[3*g +: 3];
        always_comb begin
            if (s[2] || !scaler_on)
                tap_code[3*g +: 3] = TAP_NONE;
            else if (s == 3'd3 || !bridge_on)
                tap_code[3*g +: 3] = TAP_FULL;
            else
                tap_code[3*g +: 3] = 3'(s + 3'd1);
        end
    end
endmodule

// File: rtl/cmpcfg_regs.sv
module cmpcfg_regs
    import cmpcfg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [1:0]        cmp_raw,
    output logic [1:0]        cmp_cond,
    output logic [1:0]        cfg_en,
    output logic [3:0]        cfg_pwr,
    output logic [3:0]        cfg_inp,
    output logic [5:0]        cfg_inm,
    output logic [1:0]        cfg_ext_en,
    output logic [3:0]        cfg_ext_sel,
    output logic [3:0]        cfg_hyst,
    output logic [1:0]        cfg_pol,
    output logic [5:0]        cfg_blank,
    output logic              cfg_win,
    output logic              scaler_on,
    output logic              bridge_on,
    output logic [5:0]        ref_tap
);
    logic [WORD_W-1:0] chan_word [NCH];
    logic [NCH-1:0]    seal_q;
    logic [NCH-1:0]    scal_bits, brg_bits;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [ADDR_W-1:0] OFS = ADDR_W'(g * 4);
        logic hit;
        assign hit = bus_valid && bus_write && (bus_addr == OFS);

        cmpcfg_chan #(.HAS_WIN(g == NCH - 1)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (hit),
            .wdata    (bus_wdata),
            .fields_q (chan_word[g]),
            .sealed   (seal_q[g])
        );

        assign cfg_en[g]          = chan_word[g][B_EN];
        assign cfg_pwr[2*g +: 2]  = chan_word[g][B_PWR +: 2];
        assign cfg_inp[2*g +: 2]  = chan_word[g][B_INP +: 2];
        assign cfg_inm[3*g +: 3]  = chan_word[g][B_INM +: 3];
        assign cfg_hyst[2*g +: 2] = chan_word[g][B_HYST +: 2];
        assign cfg_pol[g]         = chan_word[g][B_POL];
        assign cfg_blank[3*g +: 3] = chan_word[g][B_BLANK +: 3];
        assign scal_bits[g]       = chan_word[g][B_SCAL];
        assign brg_bits[g]        = chan_word[g][B_BRG];
        assign cfg_ext_en[g]      = (chan_word[g][B_INM +: 3] == 3'b111);
        assign cfg_ext_sel[2*g +: 2] = cfg_ext_en[g] ? chan_word[g][B_EXT +: 2] : 2'b00;
        assign cmp_cond[g]        = cmp_raw[g] ^ chan_word[g][B_POL];
    end

    assign cfg_win = chan_word[NCH-1][B_WIN];

    cmpcfg_tapsel #(.N(NCH)) u_tap (
        .inm_sel   (cfg_inm),
        .scal_bits (scal_bits),
        .brg_bits  (brg_bits),
        .scaler_on (scaler_on),
        .bridge_on (bridge_on),
        .tap_code  (ref_tap)
    );

    // Single-cycle read path
    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (bus_valid && !bus_write && bus_addr == ADDR_W'(c * 4))
                bus_rdata = {seal_q[c], cmp_cond[c], chan_word[c][29:0]};
        end
    end
endmodule

// File: rtl/cmpcfg_chk.sv
module cmpcfg_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       word0,
    input logic [31:0]       word1,
    input logic [1:0]        seal,
    input logic [3:0]        inp,
    input logic              scaler_on,
    input logic [5:0]        ref_tap
);
    a_r3_seal_sticky_c0: assert property (@(posedge clk) disable iff (!rst_n)
        seal[0] |=> seal[0]);
    a_r3_seal_sticky_c1: assert property (@(posedge clk) disable iff (!rst_n)
        seal[1] |=> seal[1]);
    a_r3_frozen_c0: assert property (@(posedge clk) disable iff (!rst_n)
        seal[0] |=> $stable(word0));
    a_r3_frozen_c1: assert property (@(posedge clk) disable iff (!rst_n)
        seal[1] |=> $stable(word1));
    a_r5_inp_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (inp[1:0] != 2'b11) && (inp[3:2] != 2'b11));
    a_r7_tap_needs_scaler: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_tap != 6'd0) |-> scaler_on);
    a_r9_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr != ADDR_W'(0) && bus_addr != ADDR_W'(4))
        |=> ($stable(word0) && $stable(word1)));
endmodule

bind cmpcfg_regs cmpcfg_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .word0     (chan_word[0]),
    .word1     (chan_word[1]),
    .seal      (seal_q),
    .inp       (cfg_inp),
    .scaler_on (scaler_on),
    .ref_tap   (ref_tap)
);

// File: tb/sim_cmpcfg_regs.sv
module sim_cmpcfg_regs;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [1:0] cmp_raw = 2'b00, cmp_cond, cfg_en, cfg_ext_en, cfg_pol;
    logic [3:0] cfg_pwr, cfg_inp, cfg_ext_sel, cfg_hyst;
    logic [5:0] cfg_inm, cfg_blank, ref_tap;
    logic cfg_win, scaler_on, bridge_on;

    int nchk = 0, nerr = 0;
    logic [31:0] shadow [2];
    bit seal [2];

    always #10 clk = ~clk;

    cmpcfg_regs #(.ADDR_W(AW)) u0 (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] mdl(input logic [31:0] old, input logic [31:0] wd, input int ch);
        logic [31:0] n;
        n = wd & ((ch == 1) ? 32'h06DF_83FD : 32'h06DF_81FD);
        if (wd[8:7] == 2'b11) n[8:7] = old[8:7];
        return n;
    endfunction

    function automatic logic [2:0] tapf(input int inm, input bit s, input bit b);
        if (inm > 3 || !s) return 3'd0;
        if (inm == 3 || !b) return 3'd4;
        return 3'(inm + 1);
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        for (int c = 0; c < 2; c++) begin shadow[c] = '0; seal[c] = 1'b0; end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        for (int c = 0; c < 2; c++) begin
            if (a == AW'(c * 4) && !seal[c]) begin
                shadow[c] = mdl(shadow[c], d, c);
                if (d[31]) seal[c] = 1'b1;
            end
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    function automatic logic [31:0] expw(input int c);
        return {seal[c], cmp_raw[c] ^ shadow[c][15], shadow[c][29:0]};
    endfunction

    task automatic chk_words(input string tag);
        logic [31:0] d;
        rd(8'h00, d); chk({tag, " ch0 word"}, d, expw(0));
        rd(8'h04, d); chk({tag, " ch1 word"}, d, expw(1));
    endtask

    task automatic chk_outs();
        #1;
        chk("R10 en/pol/win", {29'd0, cfg_win, cfg_pol[1], cfg_en[1]} |
            {30'd0, cfg_pol[0], cfg_en[0]} << 3,
            {29'd0, shadow[1][9], shadow[1][15], shadow[1][0]} |
            {30'd0, shadow[0][15], shadow[0][0]} << 3);
        chk("R10 pwr/inp/hyst", {20'd0, cfg_pwr, cfg_inp, cfg_hyst},
            {20'd0, shadow[1][3:2], shadow[0][3:2], shadow[1][8:7], shadow[0][8:7],
             shadow[1][17:16], shadow[0][17:16]});
        chk("R10 inm/blank", {20'd0, cfg_inm, cfg_blank},
            {20'd0, shadow[1][6:4], shadow[0][6:4], shadow[1][20:18], shadow[0][20:18]});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired got=running exp=done");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [31:0] pats [6];
        pats[0] = 32'h0000_0100; pats[1] = 32'h7FFF_FFFF; pats[2] = 32'h5A5A_5A5A;
        pats[3] = 32'h2000_4ABC; pats[4] = 32'h1234_5080; pats[5] = 32'h0000_0000;

        do_reset();
        // R1: reset state
        chk_words("R1");
        #1 chk("R1 outputs", {6'd0, cfg_en, cfg_pwr, cfg_inp, cfg_inm, cfg_hyst, cfg_pol, cfg_win},
               32'd0);
        chk("R1 tap/ext", {20'd0, ref_tap, cfg_ext_en, cfg_ext_sel}, 32'd0);

        // R2 / R5 / R10: pattern sweep over both words
        for (int p = 0; p < 6; p++) begin
            for (int c = 0; c < 2; c++) begin
                wr(AW'(c * 4), pats[p] ^ (c == 1 ? 32'h0000_0200 : 32'h0));
                chk_words("R2");
                chk_outs();
            end
            if (p == 1) begin
                // R5: plus select 11 kept previous 10
                rd(8'h00, d); chk("R5 ch0 inp kept", {30'd0, d[8:7]}, 32'd2);
                rd(8'h04, d); chk("R5 ch1 inp kept", {30'd0, d[8:7]}, 32'd2);
                chk("R5 other fields stored", {31'd0, d[0]}, 32'd1);
            end
        end

        // R9: unmapped offsets
        wr(8'h00, 32'h0000_0035);
        wr(8'h04, 32'h0000_0248);
        wr(8'h08, 32'h7FFF_FFFF);
        wr(8'h01, 32'h7FFF_FFFF);
        wr(8'hFC, 32'h7FFF_FFFF);
        chk_words("R9");
        rd(8'h08, d); chk("R9 read 0x08", d, 32'd0);
        rd(8'h02, d); chk("R9 read 0x02", d, 32'd0);

        // R4: raw x polarity sweep
        for (int r = 0; r < 4; r++) begin
            for (int pl = 0; pl < 4; pl++) begin
                wr(8'h00, 32'h4000_0000 | (pl[0] ? 32'h8000 : 32'h0));
                wr(8'h04, 32'h4000_0000 | (pl[1] ? 32'h8000 : 32'h0));
                cmp_raw = 2'(r);
                chk_words("R4");
                #1 chk("R4 cmp_cond", {30'd0, cmp_cond}, {30'd0, 2'(r) ^ 2'(pl)});
            end
        end
        cmp_raw = 2'b00;

        // R6 / R7 / R8: enable combos x minus select
        for (int k = 0; k < 16; k++) begin
            for (int inm = 0; inm < 8; inm++) begin
                logic [31:0] w0, w1;
                w0 = (32'(k & 1) << 23) | (32'((k >> 1) & 1) << 22) |
                     (32'(inm) << 4) | (32'(inm & 3) << 25);
                w1 = (32'((k >> 2) & 1) << 23) | (32'((k >> 3) & 1) << 22) |
                     (32'(7 - inm) << 4) | (32'd2 << 25);
                wr(8'h00, w0);
                wr(8'h04, w1);
                #1;
                chk("R6 scaler/bridge", {30'd0, scaler_on, bridge_on},
                    {30'd0, ((k & 1) | ((k >> 2) & 1)) != 0, (((k >> 1) & 1) | ((k >> 3) & 1)) != 0});
                chk("R7 tap codes", {26'd0, ref_tap},
                    {26'd0,
                     tapf(7 - inm, ((k & 5) != 0), ((k & 10) != 0)),
                     tapf(inm, ((k & 5) != 0), ((k & 10) != 0))});
                chk("R8 ext", {26'd0, cfg_ext_en, cfg_ext_sel},
                    {26'd0, inm == 0, inm == 7,
                     (inm == 0) ? 2'd2 : 2'd0, (inm == 7) ? 2'(inm & 3) : 2'd0});
            end
        end

        // R3: seal with data in one write, then frozen
        wr(8'h00, 32'h8000_0011);
        chk_words("R3 seal+data");
        rd(8'h00, d); chk("R3 seal bit set", d, 32'h8000_0011);
        wr(8'h00, 32'h0000_0000);
        wr(8'h00, 32'h7FFF_FFFF);
        rd(8'h00, d); chk("R3 sealed word frozen", d, 32'h8000_0011);
        #1 chk("R3 outputs frozen", {29'd0, cfg_inm[2:0]}, 32'd1);
        wr(8'h04, 32'h0000_0201);
        rd(8'h04, d); chk("R3 neighbour writable", d, 32'h0000_0201);
        do_reset();
        chk_words("R3 reopened by reset");
        wr(8'h00, 32'h0000_0001);
        rd(8'h00, d); chk("R3 writable after reset", d, 32'h0000_0001);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule